// File: doc/BRIEF.md
# LCD Base Clock Generator

This block derives the timing base of an LCD controller from one of three oscillator sources. Each oscillator is modelled as a one-cycle enable strobe on the system clock. The selected strobe first passes a fixed per-source pre-divider. A programmable prescaler with ratios 1:1 to 1:16 follows, and a 32-step segment counter comes last. The block issues two single-cycle strobes. A segment tick fires 32 times per LCD period for downstream segment-time counting. An LCD clock enable fires once per LCD period.

The fast internal RC source is divided by a fixed `FAST_DIV`, nominally 8192, which turns 8 MHz into about 1 kHz. The crystal source and the low-power RC source are divided by `SLOW_DIV`, nominally 32. The total ratio from the selected strobe to the LCD clock enable is therefore `DIV*(n+1)`, where n is the prescale field. A master enable turns all clocking on or off. A sleep indication freezes the divider chain unless two conditions both hold: the sleep-stop control is clear, and a source able to run in sleep (crystal or low-power RC) is selected.

A small controller sets the operating phase. It has three states:
- `ST_OFF`: counters cleared, no output.
- `ST_RUN`: counting.
- `ST_HOLD`: counters frozen, no output.

Its transitions are:
- enable rising: `ST_OFF` to `ST_RUN`.
- halt condition true: `ST_RUN` to `ST_HOLD`.
- halt released: `ST_HOLD` to `ST_RUN`.
- enable falling: any state to `ST_OFF`.

Top module: `lcdclk_gen`

## Requirements
- R1: While reset is asserted, and after reset until the block is enabled, `seg_tick` and `lcd_clk_en` are 0.
- R2: With `src_sel`=2'b00, `seg_tick` fires once every `(FAST_DIV/32)*(n+1)` strobes of `frc_stb`, where n is the value of `ps_sel`.
- R3: With `src_sel`=2'b01 (strobe `xtal_stb`) or 2'b10 (strobe `lprc_stb`), `seg_tick` fires once every `(SLOW_DIV/32)*(n+1)` strobes of that source.
- R4: Every prescale value n from 0 to 15 gives a ratio of n+1.
- R5: `lcd_clk_en` fires on every 32nd `seg_tick`, in the same cycle as that tick, so its period is `DIV*(n+1)` source strobes.
- R6: With `src_sel`=2'b11, no output strobe is produced.
- R7: While `lcd_en` is 0, both outputs stay 0 and all counters return to zero.
- R8: A change of `ps_sel` or `src_sel` restarts the pre-divider and prescaler, so the new ratio applies from the next period.
- R9: While `cpu_sleep` and `sleep_stop` are both 1, the chain is frozen and produces no strobes for any source.
- R10: While `cpu_sleep` is 1 and `sleep_stop` is 0, sources 2'b01 and 2'b10 keep running at their normal rate, and source 2'b00 is frozen.
- R11: When the sleep condition is released, counting resumes without the block being re-enabled.
- R12: Strobes of unselected sources have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frc_stb | input | 1 | Fast internal RC oscillator strobe |
| xtal_stb | input | 1 | Secondary crystal oscillator strobe |
| lprc_stb | input | 1 | Low-power internal RC oscillator strobe |
| src_sel | input | 2 | Source select: 00 fast RC, 01 crystal, 10 low-power RC, 11 none |
| ps_sel | input | PS_W | Prescale field n, ratio n+1 |
| lcd_en | input | 1 | Master enable |
| sleep_stop | input | 1 | 1 = stop the LCD clock during sleep |
| cpu_sleep | input | 1 | Processor sleep indication |
| seg_tick | output | 1 | Single-cycle tick at 32 times the LCD clock rate |
| lcd_clk_en | output | 1 | Single-cycle LCD clock enable |

## Verification
The hardest situation to reach from the ports is a prescale change in the middle of a long period. Reaching it means seeing that the short new ratio starts at once rather than after the old count ends. The bench sets ratio 16 and waits for a tick. It moves a few cycles into the period and then switches to ratio 1. It then checks the delay to the next tick and the interval between the following ticks. The sleep cases are reached by pairing each source with each sleep-stop setting while the system is asleep, then releasing sleep.

// File: rtl/lcdclk_pkg.sv
package lcdclk_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } clk_state_e;

    localparam logic [1:0] SRC_FAST = 2'b00;
    localparam logic [1:0] SRC_XTAL = 2'b01;
    localparam logic [1:0] SRC_LPRC = 2'b10;
    localparam logic [1:0] SRC_NONE = 2'b11;

endpackage

// File: rtl/lcdclk_src_mux.sv
module lcdclk_src_mux
    import lcdclk_pkg::*;
#(
    parameter int A_W      = 8,
    parameter int FAST_PRE = 256,
    parameter int SLOW_PRE = 1
) (
    input  logic [2:0]     stb_vec,
    input  logic [1:0]     src_sel,
    output logic           strobe,
    output logic [A_W-1:0] a_lim,
    output logic           can_sleep
);

    localparam logic [A_W-1:0] FAST_LIM = A_W'(FAST_PRE - 1);
    localparam logic [A_W-1:0] SLOW_LIM = A_W'(SLOW_PRE - 1);

    always_comb begin
        strobe    = 1'b0;
        a_lim     = SLOW_LIM;
        can_sleep = 1'b0;
        unique case (src_sel)
            SRC_FAST: begin
                strobe = stb_vec[0];
                a_lim  = FAST_LIM;
            end
            SRC_XTAL: begin
                strobe    = stb_vec[1];
                can_sleep = 1'b1;
            end
            SRC_LPRC: begin
                strobe    = stb_vec[2];
                can_sleep = 1'b1;
            end
            SRC_NONE: begin
                strobe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lcdclk_fsm.sv
module lcdclk_fsm
    import lcdclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       halt,
    output clk_state_e state,
    output logic       advance,
    output logic       clear
);

    clk_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_d;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_OFF:  if (enable) state_d = halt ? ST_HOLD : ST_RUN;
            ST_RUN:  if (!enable) state_d = ST_OFF;
                     else if (halt) state_d = ST_HOLD;
            ST_HOLD: if (!enable) state_d = ST_OFF;
                     else if (!halt) state_d = ST_RUN;
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        advance = 1'b0;
        clear   = 1'b0;
        unique case (state)
            ST_OFF:  clear   = 1'b1;
            ST_RUN:  advance = 1'b1;
            ST_HOLD: advance = 1'b0;
            default: clear   = 1'b1;
        endcase
    end

endmodule

// File: rtl/lcdclk_divchain.sv
module lcdclk_divchain #(
    parameter int A_W       = 8,
    parameter int PS_W      = 4,
    parameter int SEG_TICKS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            advance,
    input  logic            strobe,
    input  logic [A_W-1:0]  a_lim,
    input  logic [PS_W-1:0] ps_sel,
    input  logic [1:0]      src_sel,
    output logic            tick,
    output logic            lcd
);

    localparam int SEG_W = (SEG_TICKS > 1) ? $clog2(SEG_TICKS) : 1;
    localparam logic [SEG_W-1:0] SEG_LIM = SEG_W'(SEG_TICKS - 1);

    logic [A_W-1:0]   a_cnt;
    logic [PS_W-1:0]  p_cnt;
    logic [SEG_W-1:0] s_cnt;
    logic [PS_W-1:0]  ps_q;
    logic [1:0]       sel_q;
    logic             a_hit, p_hit, s_hit, cfg_chg;

    assign a_hit   = (a_cnt == a_lim);
    assign p_hit   = (p_cnt == ps_sel);
    assign s_hit   = (s_cnt == SEG_LIM);
    assign cfg_chg = (ps_q != ps_sel) || (sel_q != src_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_cnt <= '0;
            p_cnt <= '0;
            s_cnt <= '0;
            ps_q  <= '0;
            sel_q <= '0;
            tick  <= 1'b0;
            lcd   <= 1'b0;
        end else begin
            ps_q  <= ps_sel;
            sel_q <= src_sel;
            tick  <= 1'b0;
            lcd   <= 1'b0;
            if (clear) begin
                a_cnt <= '0;
                p_cnt <= '0;
                s_cnt <= '0;
            end else if (cfg_chg) begin
                a_cnt <= '0;
                p_cnt <= '0;
            end else if (advance && strobe) begin
                if (a_hit) begin
                    a_cnt <= '0;
                    if (p_hit) begin
                        p_cnt <= '0;
                        tick  <= 1'b1;
                        lcd   <= s_hit;
                        s_cnt <= s_hit ? '0 : s_cnt + 1'b1;
                    end else begin
                        p_cnt <= p_cnt + 1'b1;
                    end
                end else begin
                    a_cnt <= a_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/lcdclk_gen.sv
module lcdclk_gen
    import lcdclk_pkg::*;
#(
    parameter int FAST_DIV  = 8192,
    parameter int SLOW_DIV  = 32,
    parameter int SEG_TICKS = 32,
    parameter int PS_W      = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frc_stb,
    input  logic            xtal_stb,
    input  logic            lprc_stb,
    input  logic [1:0]      src_sel,
    input  logic [PS_W-1:0] ps_sel,
    input  logic            lcd_en,
    input  logic            sleep_stop,
    input  logic            cpu_sleep,
    output logic            seg_tick,
    output logic            lcd_clk_en
);

    localparam int FAST_PRE = FAST_DIV / SEG_TICKS;
    localparam int SLOW_PRE = SLOW_DIV / SEG_TICKS;
    localparam int A_W      = (FAST_PRE > 1) ? $clog2(FAST_PRE) : 1;

    logic [2:0]     stb_vec;
    logic           strobe, can_sleep, halt, advance, clear;
    logic [A_W-1:0] a_lim;
    clk_state_e     state;

    assign stb_vec = {lprc_stb, xtal_stb, frc_stb};
    assign halt    = cpu_sleep && (sleep_stop || !can_sleep);

    lcdclk_src_mux #(
        .A_W      (A_W),
        .FAST_PRE (FAST_PRE),
        .SLOW_PRE (SLOW_PRE)
    ) mux_i (
        .stb_vec   (stb_vec),
        .src_sel   (src_sel),
        .strobe    (strobe),
        .a_lim     (a_lim),
        .can_sleep (can_sleep)
    );

    lcdclk_fsm fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (lcd_en),
        .halt    (halt),
        .state   (state),
        .advance (advance),
        .clear   (clear)
    );

    lcdclk_divchain #(
        .A_W       (A_W),
        .PS_W      (PS_W),
        .SEG_TICKS (SEG_TICKS)
    ) div_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .advance (advance),
        .strobe  (strobe),
        .a_lim   (a_lim),
        .ps_sel  (ps_sel),
        .src_sel (src_sel),
        .tick    (seg_tick),
        .lcd     (lcd_clk_en)
    );

endmodule

// File: rtl/lcdclk_gen_chk.sv
module lcdclk_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] src_sel,
    input logic       lcd_en,
    input logic       sleep_stop,
    input logic       cpu_sleep,
    input logic       seg_tick,
    input logic       lcd_clk_en
);

    a_r5_lcd_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_clk_en |-> seg_tick);

    a_r5_lcd_single: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_clk_en |=> !lcd_clk_en);

    a_r6_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'b11) |=> !seg_tick);

    a_r7_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_en && $past(!lcd_en)) |=> (!seg_tick && !lcd_clk_en));

    a_r9_sleep_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cpu_sleep && (sleep_stop || src_sel == 2'b00)) |=> !seg_tick);

    always_comb begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!seg_tick && !lcd_clk_en);
        end
    end

endmodule

bind lcdclk_gen lcdclk_gen_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_sel    (src_sel),
    .lcd_en     (lcd_en),
    .sleep_stop (sleep_stop),
    .cpu_sleep  (cpu_sleep),
    .seg_tick   (seg_tick),
    .lcd_clk_en (lcd_clk_en)
);

// File: tb/lcdclk_gen_tb_top.sv
`timescale 1ns/1ps
module lcdclk_gen_tb_top;

    localparam int FAST_DIV = 64;
    localparam int SLOW_DIV = 32;
    localparam int FAST_PRE = FAST_DIV / 32;
    localparam int SLOW_PRE = SLOW_DIV / 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frc_stb = 1'b0, xtal_stb = 1'b0, lprc_stb = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic [3:0] ps_sel = 4'd0;
    logic       lcd_en = 1'b0, sleep_stop = 1'b0, cpu_sleep = 1'b0;
    logic       seg_tick, lcd_clk_en;

    int total = 0;
    int bad   = 0;
    int cyc = 0, last_tick = 0, tick_int = 0, tick_cnt = 0;
    int last_lcd = 0, lcd_int = 0, lcd_cnt = 0, ticks_since = 0, ticks_per_lcd = 0;

    always #10 clk = ~clk;

    lcdclk_gen #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .frc_stb(frc_stb), .xtal_stb(xtal_stb),
        .lprc_stb(lprc_stb), .src_sel(src_sel), .ps_sel(ps_sel), .lcd_en(lcd_en),
        .sleep_stop(sleep_stop), .cpu_sleep(cpu_sleep),
        .seg_tick(seg_tick), .lcd_clk_en(lcd_clk_en)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (seg_tick) begin
            tick_int  = cyc - last_tick;
            last_tick = cyc;
            tick_cnt  = tick_cnt + 1;
            ticks_since = ticks_since + 1;
        end
        if (lcd_clk_en) begin
            lcd_int  = cyc - last_lcd;
            last_lcd = cyc;
            lcd_cnt  = lcd_cnt + 1;
            ticks_per_lcd = ticks_since;
            ticks_since = 0;
        end
        frc_stb  = 1'b1;
        xtal_stb = (cyc % 3 == 0);
        lprc_stb = (cyc % 3 == 1);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_lcd(input int k);
        int target = lcd_cnt + k;
        while (lcd_cnt < target) @(negedge clk);
    endtask

    task automatic wait_tick();
        int target = tick_cnt + 1;
        while (tick_cnt < target) @(negedge clk);
    endtask

    task automatic run_cfg(input logic [1:0] sel, input int n, input int pre,
                           input int spacing, input string req);
        int exp_t;
        lcd_en = 1'b0;
        cycles(3);
        src_sel = sel;
        ps_sel  = 4'(n);
        cycles(2);
        lcd_en = 1'b1;
        wait_lcd(2);
        exp_t = spacing * pre * (n + 1);
        chk(tick_int == exp_t, {req, " R4 tick period"}, tick_int, exp_t);
        chk(lcd_int == 32 * exp_t, "R5 lcd period", lcd_int, 32 * exp_t);
        chk(ticks_per_lcd == 32, "R5 ticks per lcd", ticks_per_lcd, 32);
    endtask

    initial begin
        int snap, c0;
        cycles(3);
        chk(!seg_tick && !lcd_clk_en, "R1 in reset", int'(seg_tick), 0);
        rst_n = 1'b1;
        cycles(20);
        chk(tick_cnt == 0 && lcd_cnt == 0, "R1 after reset", tick_cnt, 0);

        for (int n = 0; n < 16; n++) run_cfg(2'b00, n, FAST_PRE, 1, "R2");
        for (int n = 0; n < 16; n++) run_cfg(2'b01, n, SLOW_PRE, 3, "R3 R12");
        for (int n = 0; n < 16; n++) run_cfg(2'b10, n, SLOW_PRE, 3, "R3 R12");

        // R8: shorten the ratio in the middle of a long period
        run_cfg(2'b00, 15, FAST_PRE, 1, "R2");
        wait_tick();
        cycles(5);
        ps_sel = 4'd0;
        c0 = cyc;
        wait_tick();
        chk(last_tick - c0 <= FAST_PRE + 2, "R8 restart delay", last_tick - c0, FAST_PRE + 2);
        wait_tick();
        chk(tick_int == FAST_PRE, "R8 new period", tick_int, FAST_PRE);

        // R9: sleep with stop set freezes every source
        for (int s = 0; s < 3; s++) begin
            run_cfg(2'(s), 0, (s == 0) ? FAST_PRE : SLOW_PRE, (s == 0) ? 1 : 3, "R2 R3");
            sleep_stop = 1'b1;
            cpu_sleep  = 1'b1;
            cycles(4);
            snap = tick_cnt;
            cycles(100);
            chk(tick_cnt == snap, "R9 frozen", tick_cnt - snap, 0);
            cpu_sleep = 1'b0;
            cycles(50);
            chk(tick_cnt > snap, "R11 resumes", tick_cnt - snap, 1);
            sleep_stop = 1'b0;
        end

        // R10: sleep with stop clear
        for (int s = 1; s < 3; s++) begin
            run_cfg(2'(s), 0, SLOW_PRE, 3, "R3");
            cpu_sleep = 1'b1;
            cycles(4);
            snap = tick_cnt;
            cycles(99);
            chk(tick_cnt - snap == 33, "R10 keeps running", tick_cnt - snap, 33);
            chk(tick_int == 3 * SLOW_PRE, "R10 rate", tick_int, 3 * SLOW_PRE);
            cpu_sleep = 1'b0;
        end
        run_cfg(2'b00, 0, FAST_PRE, 1, "R2");
        cpu_sleep = 1'b1;
        cycles(4);
        snap = tick_cnt;
        cycles(100);
        chk(tick_cnt == snap, "R10 fast source frozen", tick_cnt - snap, 0);
        cpu_sleep = 1'b0;
        cycles(20);
        chk(tick_cnt > snap, "R11 fast resumes", tick_cnt - snap, 1);

        // R6: no source
        src_sel = 2'b11;
        cycles(4);
        snap = tick_cnt;
        cycles(200);
        chk(tick_cnt == snap, "R6 no output", tick_cnt - snap, 0);

        // R7: disabled
        src_sel = 2'b00;
        lcd_en  = 1'b0;
        cycles(4);
        snap = tick_cnt;
        cycles(200);
        chk(tick_cnt == snap && lcd_cnt >= 0, "R7 disabled quiet", tick_cnt - snap, 0);
        snap = lcd_cnt;
        c0 = cyc;
        lcd_en = 1'b1;
        wait_lcd(1);
        chk(last_lcd - c0 == FAST_DIV + 2, "R7 counters cleared", last_lcd - c0, FAST_DIV + 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 190000);
        bad   = bad + 1;
        total = total + 1;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule